// File: doc/BRIEF.md
# Dual-Direction Message Mailbox

This block lets an application processor and an I/O processor exchange short messages through two one-way hardware queues. One queue carries traffic from the application side to the I/O side, the other carries traffic back. A message is made of a 64-bit first word and a 32-bit second word. Each processor has its own simple register port with address, write strobe, read strobe, 64-bit write data and registered 64-bit read data. Both ports decode the same address map.

The sender writes the first word into a staging register and then writes the second word. The second write pushes the whole 96-bit entry. The receiver can peek at the head first word without side effects. Reading the head second word pops the entry. That read also returns the queue's occupancy, the opposite queue's occupancy and the queue's read and write pointers.

Four queue conditions are caught by sticky latches: each queue being empty and each queue holding data. A latch is cleared by writing 1 to its acknowledge bit, and it is gated onto a level interrupt output by an enable register. Each latch is a two-state machine. `LAT_IDLE` moves to `LAT_HELD` on transition SET, taken when its condition is true and no acknowledge is written. `LAT_HELD` returns to `LAT_IDLE` on transition ACK, taken when a 1 is written to its acknowledge bit. An acknowledge wins over a condition in the same cycle. The latch therefore drops for exactly one cycle and then re-asserts if the condition persists.

Top module: `dual_fifo_mailbox`

## Requirements
- R1: After reset both queues are empty, so each control word reads bit 17 = 1 (empty) and bit 16 = 0 (full). The enable register reads 0, all four interrupt outputs are low and both read-data ports are 0.
- R2: The application port writes the first word at 0x60 and the second word at 0x68, which pushes an entry into the application-to-I/O queue. The I/O port then receives the entries in push order: 0x70 returns the first word and 0x78 returns the second word in bits 31:0 and pops the entry.
- R3: The reverse direction works the same way. The I/O port writes 0x90 and then 0x98, and the application port reads 0xA0 and then 0xA8, in push order.
- R4: Each queue holds 16 entries. When a queue is full its control word (0x50 or 0x80) shows bit 16 = 1, and a further push is ignored, leaving the stored entries and their order unchanged.
- R5: A pop of an empty queue is ignored. The queue stays empty and its pointers do not move.
- R6: A read of the first receive word (0x70 or 0xA0) does not pop, so repeated reads return the same entry.
- R7: The second receive word carries status taken before the pop. Bits 56:52 hold this queue's occupancy, bits 51:48 the opposite queue's occupancy saturated at 15, bits 47:44 this queue's read pointer and bits 43:40 its write pointer. Bits 39:32 and 63:57 read 0.
- R8: Interrupt bit order is fixed. Bit 0 is application-to-I/O empty, bit 1 application-to-I/O holding data, bit 2 I/O-to-application empty and bit 3 I/O-to-application holding data. A condition that holds for a cycle sets its latch, and the latches read back at 0x4C.
- R9: A set latch stays set after its condition goes away, until it is acknowledged.
- R10: Writing 1 to a bit of 0x4C clears that latch for one cycle. The latch sets again on the following cycle only if its condition still holds.
- R11: The enable register at 0x48 (bits 3:0, read back) gates each latch onto its output. send-empty, send-not-empty, recv-empty and recv-not-empty follow bits 0 to 3 respectively.
- R12: Writes to a queue's send words from the receiving side's port are ignored. A read of a receive second word from the sending side's port returns data but does not pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ap_addr | input | 8 | Application port register offset |
| ap_wr | input | 1 | Application port write strobe |
| ap_rd | input | 1 | Application port read strobe |
| ap_wdata | input | 64 | Application port write data |
| ap_rdata | output | 64 | Application port read data, valid the cycle after the read strobe |
| io_addr | input | 8 | I/O port register offset |
| io_wr | input | 1 | I/O port write strobe |
| io_rd | input | 1 | I/O port read strobe |
| io_wdata | input | 64 | I/O port write data |
| io_rdata | output | 64 | I/O port read data, valid the cycle after the read strobe |
| irq_send_empty | output | 1 | Latched application-to-I/O empty, gated by enable bit 0 |
| irq_send_not_empty | output | 1 | Latched application-to-I/O holding data, gated by enable bit 1 |
| irq_recv_empty | output | 1 | Latched I/O-to-application empty, gated by enable bit 2 |
| irq_recv_not_empty | output | 1 | Latched I/O-to-application holding data, gated by enable bit 3 |

## Verification
Several properties are checked on every cycle. A queue is never flagged full and empty at once. An overflowing push or an underflowing pop leaves the occupancy unchanged. An acknowledged latch is low on the next cycle, an unacknowledged condition always sets its latch, and a set latch with no acknowledge stays set. The bench's scenarios are needed for the rest: message ordering through the staging register, the contents of the status fields, non-popping peeks, port-role filtering, enable gating and the one-cycle drop and re-assertion of an acknowledged output, all of which need an expected value computed from the traffic history.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int ADDR_W  = 8;
    localparam int REG_W   = 64;
    localparam int NUM_IRQ = 4;

    // Register offsets; both ports decode the same map
    localparam logic [ADDR_W-1:0] OFS_IRQ_EN   = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_IRQ_ACK  = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_A2I_CTRL = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_A2I_TX0  = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_A2I_TX1  = 8'h68;
    localparam logic [ADDR_W-1:0] OFS_A2I_RX0  = 8'h70;
    localparam logic [ADDR_W-1:0] OFS_A2I_RX1  = 8'h78;
    localparam logic [ADDR_W-1:0] OFS_I2A_CTRL = 8'h80;
    localparam logic [ADDR_W-1:0] OFS_I2A_TX0  = 8'h90;
    localparam logic [ADDR_W-1:0] OFS_I2A_TX1  = 8'h98;
    localparam logic [ADDR_W-1:0] OFS_I2A_RX0  = 8'hA0;
    localparam logic [ADDR_W-1:0] OFS_I2A_RX1  = 8'hA8;

    // Interrupt bit positions
    localparam int IRQ_A2I_EMPTY = 0;
    localparam int IRQ_A2I_DATA  = 1;
    localparam int IRQ_I2A_EMPTY = 2;
    localparam int IRQ_I2A_DATA  = 3;

    typedef struct packed {
        logic [63:0] w0;
        logic [31:0] w1;
    } msg_t;

    typedef enum logic {
        LAT_IDLE = 1'b0,
        LAT_HELD = 1'b1
    } lat_state_e;

    function automatic logic [REG_W-1:0] ctrl_word(input logic full, input logic empty);
        logic [REG_W-1:0] w;
        w     = '0;
        w[16] = full;
        w[17] = empty;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] status_word(input logic [4:0]  occ,
                                                    input logic [3:0]  other,
                                                    input logic [3:0]  rp,
                                                    input logic [3:0]  wp,
                                                    input logic [31:0] payload);
        return {7'b0, occ, other, rp, wp, 8'b0, payload};
    endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo
    import mbx_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  msg_t             din,
    input  logic             pop,
    output msg_t             head,
    output logic             full,
    output logic             empty,
    output logic [PTR_W:0]   count,
    output logic [PTR_W-1:0] rptr,
    output logic [PTR_W-1:0] wptr
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W:0]   FULL_CNT = (PTR_W+1)'(DEPTH);

    msg_t mem [DEPTH];
    logic push_ok;
    logic pop_ok;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) begin
                wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
            end
            if (pop_ok) begin
                rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/mbx_irq_latch.sv
module mbx_irq_latch
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic ack,
    output logic held
);

    lat_state_e state_q;
    lat_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LAT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        held    = 1'b0;
        unique case (state_q)
            LAT_IDLE: begin
                if (cond && !ack) begin
                    state_d = LAT_HELD;    // SET
                end
            end
            LAT_HELD: begin
                held = 1'b1;
                if (ack) begin
                    state_d = LAT_IDLE;    // ACK
                end
            end
            default: state_d = LAT_IDLE;
        endcase
    end

endmodule

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
    import mbx_pkg::*;
#(
    parameter bit IS_APP = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              stage_we,
    output logic              push_req,
    output logic              pop_req,
    output logic              ie_we,
    output logic              ack_we
);

    // The application side feeds the A2I queue and drains I2A; the I/O side the reverse
    localparam logic [ADDR_W-1:0] OWN_TX0 = IS_APP ? OFS_A2I_TX0 : OFS_I2A_TX0;
    localparam logic [ADDR_W-1:0] OWN_TX1 = IS_APP ? OFS_A2I_TX1 : OFS_I2A_TX1;
    localparam logic [ADDR_W-1:0] OWN_RX1 = IS_APP ? OFS_I2A_RX1 : OFS_A2I_RX1;

    assign stage_we = wr && (addr == OWN_TX0);
    assign push_req = wr && (addr == OWN_TX1);
    assign pop_req  = rd && (addr == OWN_RX1);
    assign ie_we    = wr && (addr == OFS_IRQ_EN);
    assign ack_we   = wr && (addr == OFS_IRQ_ACK);

endmodule

// File: rtl/dual_fifo_mailbox.sv
module dual_fifo_mailbox
    import mbx_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ap_addr,
    input  logic              ap_wr,
    input  logic              ap_rd,
    input  logic [REG_W-1:0]  ap_wdata,
    output logic [REG_W-1:0]  ap_rdata,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [REG_W-1:0]  io_wdata,
    output logic [REG_W-1:0]  io_rdata,
    output logic              irq_send_empty,
    output logic              irq_send_not_empty,
    output logic              irq_recv_empty,
    output logic              irq_recv_not_empty
);

    localparam logic [PTR_W:0] SAT_CNT = (PTR_W+1)'(15);

    // Port decode
    logic ap_stage_we, ap_push_req, ap_pop_req, ap_ie_we, ap_ack_we;
    logic io_stage_we, io_push_req, io_pop_req, io_ie_we, io_ack_we;

    mbx_port_dec #(.IS_APP(1'b1)) u_ap_dec (
        .addr(ap_addr), .wr(ap_wr), .rd(ap_rd),
        .stage_we(ap_stage_we), .push_req(ap_push_req), .pop_req(ap_pop_req),
        .ie_we(ap_ie_we), .ack_we(ap_ack_we)
    );

    mbx_port_dec #(.IS_APP(1'b0)) u_io_dec (
        .addr(io_addr), .wr(io_wr), .rd(io_rd),
        .stage_we(io_stage_we), .push_req(io_push_req), .pop_req(io_pop_req),
        .ie_we(io_ie_we), .ack_we(io_ack_we)
    );

    // Staging registers for the first message word
    logic [63:0] a2i_stage;
    logic [63:0] i2a_stage;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a2i_stage <= '0;
            i2a_stage <= '0;
        end else begin
            if (ap_stage_we) a2i_stage <= ap_wdata;
            if (io_stage_we) i2a_stage <= io_wdata;
        end
    end

    // Queues
    logic             a2i_push, a2i_pop, a2i_full, a2i_empty;
    logic             i2a_push, i2a_pop, i2a_full, i2a_empty;
    msg_t             a2i_din, a2i_head, i2a_din, i2a_head;
    logic [PTR_W:0]   a2i_cnt, i2a_cnt;
    logic [PTR_W-1:0] a2i_rptr, a2i_wptr, i2a_rptr, i2a_wptr;

    assign a2i_push = ap_push_req;
    assign a2i_pop  = io_pop_req;
    assign i2a_push = io_push_req;
    assign i2a_pop  = ap_pop_req;
    assign a2i_din  = '{w0: a2i_stage, w1: ap_wdata[31:0]};
    assign i2a_din  = '{w0: i2a_stage, w1: io_wdata[31:0]};

    mbx_fifo #(.DEPTH(DEPTH)) u_a2i_fifo (
        .clk(clk), .rst_n(rst_n), .push(a2i_push), .din(a2i_din), .pop(a2i_pop),
        .head(a2i_head), .full(a2i_full), .empty(a2i_empty), .count(a2i_cnt),
        .rptr(a2i_rptr), .wptr(a2i_wptr)
    );

    mbx_fifo #(.DEPTH(DEPTH)) u_i2a_fifo (
        .clk(clk), .rst_n(rst_n), .push(i2a_push), .din(i2a_din), .pop(i2a_pop),
        .head(i2a_head), .full(i2a_full), .empty(i2a_empty), .count(i2a_cnt),
        .rptr(i2a_rptr), .wptr(i2a_wptr)
    );

    // Interrupt enable, acknowledge and latches
    logic [NUM_IRQ-1:0] ie_q;
    logic [NUM_IRQ-1:0] irq_ack;
    logic [NUM_IRQ-1:0] irq_cond;
    logic [NUM_IRQ-1:0] irq_lat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= '0;
        end else if (ap_ie_we) begin
            ie_q <= ap_wdata[NUM_IRQ-1:0];
        end else if (io_ie_we) begin
            ie_q <= io_wdata[NUM_IRQ-1:0];
        end
    end

    assign irq_ack = ({NUM_IRQ{ap_ack_we}} & ap_wdata[NUM_IRQ-1:0])
                   | ({NUM_IRQ{io_ack_we}} & io_wdata[NUM_IRQ-1:0]);

    always_comb begin
        irq_cond                = '0;
        irq_cond[IRQ_A2I_EMPTY] = a2i_empty;
        irq_cond[IRQ_A2I_DATA]  = !a2i_empty;
        irq_cond[IRQ_I2A_EMPTY] = i2a_empty;
        irq_cond[IRQ_I2A_DATA]  = !i2a_empty;
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_lat
        mbx_irq_latch u_lat (
            .clk(clk), .rst_n(rst_n), .cond(irq_cond[g]), .ack(irq_ack[g]),
            .held(irq_lat[g])
        );
    end

    assign irq_send_empty     = irq_lat[IRQ_A2I_EMPTY] & ie_q[IRQ_A2I_EMPTY];
    assign irq_send_not_empty = irq_lat[IRQ_A2I_DATA]  & ie_q[IRQ_A2I_DATA];
    assign irq_recv_empty     = irq_lat[IRQ_I2A_EMPTY] & ie_q[IRQ_I2A_EMPTY];
    assign irq_recv_not_empty = irq_lat[IRQ_I2A_DATA]  & ie_q[IRQ_I2A_DATA];

    // Status words returned by the second receive word
    logic [3:0]       a2i_sat, i2a_sat;
    logic [REG_W-1:0] a2i_status, i2a_status;

    assign a2i_sat    = (a2i_cnt > SAT_CNT) ? 4'hF : 4'(a2i_cnt);
    assign i2a_sat    = (i2a_cnt > SAT_CNT) ? 4'hF : 4'(i2a_cnt);
    assign a2i_status = status_word(5'(a2i_cnt), i2a_sat, 4'(a2i_rptr), 4'(a2i_wptr), a2i_head.w1);
    assign i2a_status = status_word(5'(i2a_cnt), a2i_sat, 4'(i2a_rptr), 4'(i2a_wptr), i2a_head.w1);

    // Read path, one registered mux per port
    logic [ADDR_W-1:0] rd_addr [2];
    logic              rd_en   [2];
    logic [REG_W-1:0]  rd_q    [2];

    assign rd_addr[0] = ap_addr;
    assign rd_addr[1] = io_addr;
    assign rd_en[0]   = ap_rd;
    assign rd_en[1]   = io_rd;

    for (genvar p = 0; p < 2; p++) begin : g_rd
        logic [REG_W-1:0] mux;

        always_comb begin
            case (rd_addr[p])
                OFS_IRQ_EN:   mux = {{(REG_W-NUM_IRQ){1'b0}}, ie_q};
                OFS_IRQ_ACK:  mux = {{(REG_W-NUM_IRQ){1'b0}}, irq_lat};
                OFS_A2I_CTRL: mux = ctrl_word(a2i_full, a2i_empty);
                OFS_A2I_RX0:  mux = a2i_head.w0;
                OFS_A2I_RX1:  mux = a2i_status;
                OFS_I2A_CTRL: mux = ctrl_word(i2a_full, i2a_empty);
                OFS_I2A_RX0:  mux = i2a_head.w0;
                OFS_I2A_RX1:  mux = i2a_status;
                default:      mux = '0;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_q[p] <= '0;
            end else if (rd_en[p]) begin
                rd_q[p] <= mux;
            end
        end
    end

    assign ap_rdata = rd_q[0];
    assign io_rdata = rd_q[1];

endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
    parameter  int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           a2i_full,
    input logic           a2i_empty,
    input logic [PTR_W:0] a2i_cnt,
    input logic           a2i_push,
    input logic           a2i_pop,
    input logic           i2a_full,
    input logic           i2a_empty,
    input logic [PTR_W:0] i2a_cnt,
    input logic           i2a_push,
    input logic           i2a_pop,
    input logic [3:0]     irq_cond,
    input logic [3:0]     irq_ack,
    input logic [3:0]     irq_lat
);

    assert_a2i_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(a2i_full && a2i_empty));

    assert_i2a_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(i2a_full && i2a_empty));

    assert_a2i_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (a2i_push && a2i_full && !a2i_pop) |=> $stable(a2i_cnt));

    assert_i2a_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (i2a_push && i2a_full && !i2a_pop) |=> $stable(i2a_cnt));

    assert_a2i_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (a2i_pop && a2i_empty && !a2i_push) |=> $stable(a2i_cnt));

    assert_i2a_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (i2a_pop && i2a_empty && !i2a_push) |=> $stable(i2a_cnt));

    assert_latch_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_cond & ~irq_ack) != 4'b0) |=>
            ((irq_lat & $past(irq_cond & ~irq_ack)) == $past(irq_cond & ~irq_ack)));

    assert_latch_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_lat & ~irq_ack) != 4'b0) |=>
            ((irq_lat & $past(irq_lat & ~irq_ack)) == $past(irq_lat & ~irq_ack)));

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack != 4'b0) |=> ((irq_lat & $past(irq_ack)) == 4'b0));

endmodule

bind dual_fifo_mailbox mbx_chk #(.DEPTH(DEPTH)) u_mbx_chk (
    .clk(clk), .rst_n(rst_n),
    .a2i_full(a2i_full), .a2i_empty(a2i_empty), .a2i_cnt(a2i_cnt),
    .a2i_push(a2i_push), .a2i_pop(a2i_pop),
    .i2a_full(i2a_full), .i2a_empty(i2a_empty), .i2a_cnt(i2a_cnt),
    .i2a_push(i2a_push), .i2a_pop(i2a_pop),
    .irq_cond(irq_cond), .irq_ack(irq_ack), .irq_lat(irq_lat)
);

// File: tb/test_dual_fifo_mailbox.sv
module test_dual_fifo_mailbox;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ap_addr = '0, io_addr = '0;
    logic        ap_wr = 1'b0, ap_rd = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
    logic [63:0] ap_wdata = '0, io_wdata = '0;
    logic [63:0] ap_rdata, io_rdata;
    logic        irq_send_empty, irq_send_not_empty, irq_recv_empty, irq_recv_not_empty;
    logic [3:0]  irq_v;

    int n_checks = 0;
    int n_errors = 0;

    // Scoreboard: expected entries {w0, w1} and pointer model, index 0 = A2I, 1 = I2A
    logic [95:0] sb_a2i [$];
    logic [95:0] sb_i2a [$];
    int rp [2];
    int wp [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign irq_v = {irq_recv_not_empty, irq_recv_empty, irq_send_not_empty, irq_send_empty};

    dual_fifo_mailbox #(.DEPTH(DEPTH)) i_dual_fifo_mailbox (
        .clk(clk), .rst_n(rst_n),
        .ap_addr(ap_addr), .ap_wr(ap_wr), .ap_rd(ap_rd), .ap_wdata(ap_wdata), .ap_rdata(ap_rdata),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .irq_send_empty(irq_send_empty), .irq_send_not_empty(irq_send_not_empty),
        .irq_recv_empty(irq_recv_empty), .irq_recv_not_empty(irq_recv_not_empty)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input bit io, input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        if (io) begin io_addr = a; io_wdata = d; io_wr = 1'b1; end
        else    begin ap_addr = a; ap_wdata = d; ap_wr = 1'b1; end
        @(negedge clk);
        io_wr = 1'b0;
        ap_wr = 1'b0;
    endtask

    task automatic bus_rd(input bit io, input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        if (io) begin io_addr = a; io_rd = 1'b1; end
        else    begin ap_addr = a; ap_rd = 1'b1; end
        @(negedge clk);
        io_rd = 1'b0;
        ap_rd = 1'b0;
        d = io ? io_rdata : ap_rdata;
    endtask

    function automatic logic [63:0] exp_status(int occ, int other, int r, int w, logic [31:0] pl);
        logic [3:0] o4;
        o4 = (other > 15) ? 4'hF : 4'(other);
        return {7'b0, 5'(occ), o4, 4'(r), 4'(w), 8'b0, pl};
    endfunction

    // Driver: dir 0 sends from the application port, dir 1 from the I/O port
    task automatic send(input int dir, input logic [63:0] w0, input logic [31:0] w1);
        bus_wr(dir == 1, (dir == 0) ? 8'h60 : 8'h90, w0);
        bus_wr(dir == 1, (dir == 0) ? 8'h68 : 8'h98, {32'hDEAD_BEEF, w1});
        if (dir == 0) begin
            if (sb_a2i.size() < DEPTH) begin sb_a2i.push_back({w0, w1}); wp[0] = (wp[0] + 1) % DEPTH; end
        end else begin
            if (sb_i2a.size() < DEPTH) begin sb_i2a.push_back({w0, w1}); wp[1] = (wp[1] + 1) % DEPTH; end
        end
    endtask

    // Monitor: receive on the opposite port and compare against the scoreboard
    task automatic recv(input int dir, input string req);
        logic [63:0] d0, d1;
        logic [95:0] e;
        int occ, other;
        bus_rd(dir == 0, (dir == 0) ? 8'h70 : 8'hA0, d0);
        bus_rd(dir == 0, (dir == 0) ? 8'h78 : 8'hA8, d1);
        if (dir == 0) begin
            occ = sb_a2i.size(); other = sb_i2a.size(); e = sb_a2i.pop_front();
        end else begin
            occ = sb_i2a.size(); other = sb_a2i.size(); e = sb_i2a.pop_front();
        end
        check(req, d0, e[95:32]);
        check({req, "/R7"}, d1, exp_status(occ, other, rp[dir], wp[dir], e[31:0]));
        rp[dir] = (rp[dir] + 1) % DEPTH;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [63:0] d;
        rp[0] = 0; rp[1] = 0; wp[0] = 0; wp[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 rdata", {ap_rdata ^ io_rdata}, 64'h0);
        check("R1 irq", {60'b0, irq_v}, 64'h0);
        bus_rd(0, 8'h50, d); check("R1 a2i ctrl", d, 64'h2_0000);
        bus_rd(1, 8'h80, d); check("R1 i2a ctrl", d, 64'h2_0000);
        bus_rd(0, 8'h48, d); check("R1 enable", d, 64'h0);

        // R2 / R6: three messages, peek twice then drain
        send(0, 64'h1111_2222_3333_4444, 32'hA000_0001);
        send(0, 64'h5555_6666_7777_8888, 32'hA000_0002);
        send(0, 64'h9999_AAAA_BBBB_CCCC, 32'hA000_0003);
        bus_rd(1, 8'h70, d); check("R6 peek1", d, 64'h1111_2222_3333_4444);
        bus_rd(1, 8'h70, d); check("R6 peek2", d, 64'h1111_2222_3333_4444);
        bus_rd(1, 8'h50, d); check("R6 not popped", d, 64'h0);
        for (int i = 0; i < 3; i++) recv(0, "R2 a2i order");

        // R3: reverse direction, with one A2I entry pending for the other-occupancy field
        send(0, 64'hFEED_0000_0000_0001, 32'hB000_0001);
        send(1, 64'h0123_4567_89AB_CDEF, 32'hC000_0001);
        send(1, 64'h0F0F_0F0F_F0F0_F0F0, 32'hC000_0002);
        recv(1, "R3 i2a order");
        recv(1, "R3 i2a order");

        // R12: wrong-port writes and non-popping read from the sender
        bus_wr(1, 8'h60, 64'hBAD0_BAD0_BAD0_BAD0);
        bus_wr(1, 8'h68, 64'hBAD1);
        bus_rd(0, 8'h78, d);
        check("R12 sender read no pop", d, exp_status(1, 0, rp[0], wp[0], 32'hB000_0001));
        recv(0, "R12 entry intact");
        bus_rd(1, 8'h50, d); check("R12 wrong port push ignored", d, 64'h2_0000);

        // R4: fill, overflow attempt, drain
        for (int i = 0; i < DEPTH; i++) send(0, 64'hC0DE_0000_0000_0000 + 64'(i), 32'(i) + 32'h100);
        bus_rd(1, 8'h50, d); check("R4 full flag", d, 64'h1_0000);
        send(0, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF);
        bus_rd(1, 8'h50, d); check("R4 still full", d, 64'h1_0000);
        for (int i = 0; i < DEPTH; i++) recv(0, "R4 drain order");
        bus_rd(1, 8'h50, d); check("R4 empty after drain", d, 64'h2_0000);

        // R5: pop of an empty queue
        bus_rd(1, 8'h78, d);
        check("R5 empty pop fields", {d[63:32], 32'h0}, {exp_status(0, 0, rp[0], wp[0], 32'h0)});
        bus_rd(1, 8'h78, d);
        check("R5 pointers unmoved", {d[63:32], 32'h0}, {exp_status(0, 0, rp[0], wp[0], 32'h0)});
        bus_rd(1, 8'h50, d); check("R5 still empty", d, 64'h2_0000);

        // R8 / R9: every condition was seen; data latches stay although queues are empty
        bus_rd(0, 8'h4C, d); check("R8 R9 latches", d, 64'hF);
        bus_wr(1, 8'h4C, 64'hF);
        bus_rd(0, 8'h4C, d); check("R10 reassert only live", d, 64'h5);

        // R11: enable gating and bit order
        bus_wr(0, 8'h48, 64'hF);
        bus_rd(1, 8'h48, d); check("R11 enable readback", d, 64'hF);
        check("R11 outputs all enabled", {60'b0, irq_v}, 64'h5);
        bus_wr(1, 8'h48, 64'h4);
        check("R11 only recv-empty", {60'b0, irq_v}, 64'h4);
        bus_wr(0, 8'h48, 64'hF);

        // R9 / R10 on outputs
        send(0, 64'h7777_0000_0000_0007, 32'h7);
        @(negedge clk);
        check("R9 send-empty sticky, data set", {60'b0, irq_v}, 64'h7);
        bus_wr(0, 8'h4C, 64'h1);
        @(negedge clk);
        check("R10 ack with condition gone", {63'b0, irq_send_empty}, 64'h0);
        bus_wr(0, 8'h4C, 64'h2);
        check("R10 drop cycle", {63'b0, irq_send_not_empty}, 64'h0);
        @(negedge clk);
        check("R10 reassert", {63'b0, irq_send_not_empty}, 64'h1);
        recv(0, "R2 final");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule